// File: doc/BRIEF.md
# ATM Cell Receive Mover

This block takes received ATM cells from a PHY receive port and places them, one byte at a time, into a two-entry interface FIFO. A downstream bus-transfer engine drains that FIFO. While idle, the block watches the PHY's cell-available line. When a cell is waiting, it raises a pending flag to the downstream engine and holds there until the engine grants the transfer. After the grant it reads the 53 bytes of the cell with no pauses. It reads one byte per receive tick, and the tick is derived by dividing the system clock.

Every FIFO entry is nine bits wide. The low eight bits hold the byte and the top bit copies the PHY's start-of-cell marker. Bytes that arrive before the first start-of-cell marker are thrown away and latch a framing error. A byte that finds the FIFO full while no read is taking place is also dropped, and it latches an overflow error. Both error flags clear only on reset. The receive tick is a single-cycle enable, and all logic runs on the one system clock.

Top module: `cell_rx_mover`

## Requirements
- R1: After reset, cell_pending, phy_rd_en, fifo_valid, fifo_full, ovf_err and frm_err are all 0.
- R2: phy_rx_tick is a one-cycle pulse that repeats every DIV system clocks (DIV = 16 by default).
- R3: While idle, a high phy_cell_avail raises cell_pending. cell_pending then stays high, and no PHY read is issued, until dn_ready is seen high.
- R4: After the grant, phy_rd_en is asserted on every receive tick, 16 clocks apart, with no gap. This continues until 53 bytes have been accepted into the cell. The PHY byte and marker are sampled in the same cycle as phy_rd_en.
- R5: Each accepted byte enters the FIFO as {phy_soc, phy_byte}: bit 8 is the start-of-cell marker and bits 7:0 are the data. Entries leave the FIFO in arrival order, and fifo_word shows the oldest entry while fifo_valid is 1.
- R6: The FIFO holds 2 entries. A byte written while the FIFO is full, with no pop in the same cycle, is dropped and sets ovf_err, which stays set until reset.
- R7: A write and a pop in the same cycle on a full FIFO both take effect: the byte is stored, fifo_full stays 1 and ovf_err is not set.
- R8: At the start of a cell, bytes read with phy_soc = 0 are discarded and not counted, and each one sets frm_err, which stays set until reset. Counting begins at the first byte with phy_soc = 1.
- R9: After the 53rd byte the block returns to idle. It does not raise cell_pending again until dn_ready has been seen low, even if phy_cell_avail is high.
- R10: A pop on an empty FIFO is ignored and leaves the contents and order of later entries unaffected.
- R11: phy_rd_en is never asserted outside a granted transfer. The PHY's byte and marker lines are ignored on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_cell_avail | input | 1 | PHY has a complete received cell waiting |
| phy_byte | input | 8 | Receive byte from the PHY |
| phy_soc | input | 1 | PHY start-of-cell marker for phy_byte |
| phy_rx_tick | output | 1 | One-cycle receive-rate enable for the PHY port |
| phy_rd_en | output | 1 | Reads a byte from the PHY in this cycle |
| dn_ready | input | 1 | Downstream engine grants and holds a cell transfer |
| cell_pending | output | 1 | A cell is waiting for the downstream grant |
| fifo_pop | input | 1 | Downstream removes the head FIFO entry |
| fifo_word | output | 9 | Head entry: bit 8 start-of-cell, bits 7:0 data |
| fifo_valid | output | 1 | FIFO holds at least one entry |
| fifo_full | output | 1 | FIFO holds two entries |
| ovf_err | output | 1 | Sticky: a byte was dropped because the FIFO was full |
| frm_err | output | 1 | Sticky: bytes were discarded while waiting for start-of-cell |

## Verification
A byte write from the receive side and a pop from the downstream side can land on the same clock edge. This matters most when both entries are occupied. To provoke it, the bench's consumer waits until the FIFO is full and then pops only in the cycles where phy_rd_en is high. Every write therefore meets a full FIFO together with a pop. The result is judged correct when ovf_err stays 0, fifo_full stays high and all 53 tagged bytes come out in order. A second run that never pops shows the opposite case: exactly the first two bytes are kept and ovf_err latches.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              soc;
        logic [BYTE_W-1:0] data;
    } cell_word_t;

    typedef enum logic [1:0] {
        ST_POLL = 2'd0,
        ST_PEND = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } rx_state_t;

    function automatic cell_word_t make_word(input logic soc, input logic [BYTE_W-1:0] data);
        cell_word_t w;
        w.soc  = soc;
        w.data = data;
        return w;
    endfunction

endpackage

// File: rtl/cellrx_ratediv.sv
module cellrx_ratediv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R2: a tick never lasts more than one cycle
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/cellrx_fifo.sv
module cellrx_fifo
    import cellrx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  cell_word_t push_word,
    input  logic       pop,
    output cell_word_t head,
    output logic       valid,
    output logic       full,
    output logic       dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

    cell_word_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_pop, do_push;

    assign valid   = (count != '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && valid;
    assign do_push = push && (!full || do_pop);
    assign dropped = push && !do_push;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PLAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PLAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: a write into a full FIFO without a pop changes nothing
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(count)));

    // R7: write and pop together on a full FIFO keep it full
    assert_pushpop_full_R7: assert property (@(posedge clk) disable iff (rst)
        (full && push && pop) |=> full);

    // R10: popping an empty FIFO leaves it empty
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (!valid && !push) |=> !valid);

endmodule

// File: rtl/cellrx_ctrl.sv
module cellrx_ctrl
    import cellrx_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              phy_cell_avail,
    input  logic [BYTE_W-1:0] phy_byte,
    input  logic              phy_soc,
    input  logic              dn_ready,
    input  logic              fifo_dropped,
    output logic              phy_rd_en,
    output logic              cell_pending,
    output logic              push,
    output cell_word_t        push_word,
    output logic              ovf_err,
    output logic              frm_err
);
    localparam int BC_W = $clog2(CELL_BYTES);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(CELL_BYTES - 1);

    rx_state_t       state;
    logic [BC_W-1:0] bcnt;
    logic            hunting;
    logic            discard;

    assign phy_rd_en    = (state == ST_XFER) && tick;
    assign cell_pending = (state == ST_PEND);
    assign push         = phy_rd_en && (!hunting || phy_soc);
    assign discard      = phy_rd_en && hunting && !phy_soc;
    assign push_word    = make_word(phy_soc, phy_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_POLL;
            bcnt    <= '0;
            hunting <= 1'b1;
            ovf_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            ovf_err <= ovf_err | fifo_dropped;
            frm_err <= frm_err | discard;
            case (state)
                ST_POLL: if (phy_cell_avail) state <= ST_PEND;
                ST_PEND: if (dn_ready) begin
                    state   <= ST_XFER;
                    bcnt    <= '0;
                    hunting <= 1'b1;
                end
                ST_XFER: if (push) begin
                    hunting <= 1'b0;
                    if (bcnt == BC_LAST) begin
                        bcnt  <= '0;
                        state <= ST_DONE;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_DONE: if (!dn_ready) state <= ST_POLL;
                default: state <= ST_POLL;
            endcase
        end
    end

    // R3: pending holds until the grant arrives
    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cell_pending && !dn_ready) |=> cell_pending);

    // R6: overflow flag is sticky
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    // R8: framing flag is sticky
    assert_frm_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        frm_err |=> frm_err);

    // R9: no new pending while the grant is still held after a cell
    assert_no_repend_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && dn_ready) |=> !cell_pending);

endmodule

// File: rtl/cell_rx_mover.sv
module cell_rx_mover
    import cellrx_pkg::*;
#(
    parameter int DIV        = 16,
    parameter int CELL_BYTES = 53,
    parameter int FIFO_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       phy_cell_avail,
    input  logic [7:0] phy_byte,
    input  logic       phy_soc,
    output logic       phy_rx_tick,
    output logic       phy_rd_en,
    input  logic       dn_ready,
    output logic       cell_pending,
    input  logic       fifo_pop,
    output logic [8:0] fifo_word,
    output logic       fifo_valid,
    output logic       fifo_full,
    output logic       ovf_err,
    output logic       frm_err
);
    logic       tick;
    logic       push;
    logic       dropped;
    cell_word_t push_word;
    cell_word_t head;

    cellrx_ratediv #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cellrx_ctrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .tick           (tick),
        .phy_cell_avail (phy_cell_avail),
        .phy_byte       (phy_byte),
        .phy_soc        (phy_soc),
        .dn_ready       (dn_ready),
        .fifo_dropped   (dropped),
        .phy_rd_en      (phy_rd_en),
        .cell_pending   (cell_pending),
        .push           (push),
        .push_word      (push_word),
        .ovf_err        (ovf_err),
        .frm_err        (frm_err)
    );

    cellrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (push_word),
        .pop       (fifo_pop),
        .head      (head),
        .valid     (fifo_valid),
        .full      (fifo_full),
        .dropped   (dropped)
    );

    assign phy_rx_tick = tick;
    assign fifo_word   = head;

    // R11: a PHY read only happens on a receive tick
    assert_read_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
        phy_rd_en |-> phy_rx_tick);

endmodule

// File: tb/cell_rx_mover_tb_top.sv
module cell_rx_mover_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phy_cell_avail = 1'b0;
    logic [7:0] phy_byte;
    logic       phy_soc;
    logic       phy_rx_tick, phy_rd_en;
    logic       dn_ready = 1'b0;
    logic       cell_pending;
    logic       fifo_pop;
    logic [8:0] fifo_word;
    logic       fifo_valid, fifo_full, ovf_err, frm_err;

    always #2 clk = ~clk;

    cell_rx_mover dut_i (
        .clk(clk), .rst(rst), .phy_cell_avail(phy_cell_avail),
        .phy_byte(phy_byte), .phy_soc(phy_soc), .phy_rx_tick(phy_rx_tick),
        .phy_rd_en(phy_rd_en), .dn_ready(dn_ready), .cell_pending(cell_pending),
        .fifo_pop(fifo_pop), .fifo_word(fifo_word), .fifo_valid(fifo_valid),
        .fifo_full(fifo_full), .ovf_err(ovf_err), .frm_err(frm_err)
    );

    int n_chk = 0, n_bad = 0;
    logic [8:0] phy_mem [0:63];
    logic [8:0] got [0:63];
    int phy_len = 0, phy_idx = 0, got_n = 0, pop_mode = 0;
    int rd_cnt = 0, rd_last = -1, rd_gap_bad = 0, rd_stray = 0;
    int cyc = 0, tick_last = -1, tick_bad = 0, tick_seen = 0;
    bit in_xfer = 1'b0;

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // PHY model, consumer and monitors, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (phy_rd_en) begin
            if (!in_xfer) rd_stray++;
            if (rd_last >= 0 && cyc - rd_last != 16) rd_gap_bad++;
            rd_last = cyc;
            rd_cnt++;
            if (phy_idx < phy_len) {phy_soc, phy_byte} = phy_mem[phy_idx];
            else {phy_soc, phy_byte} = 9'h000;
            phy_idx++;
        end else begin
            phy_soc  = 1'b1;     // junk marker on idle cycles
            phy_byte = 8'hEE;
        end
        if (rst) tick_last = -1;
        else if (phy_rx_tick) begin
            if (tick_last >= 0 && cyc - tick_last != 16) tick_bad++;
            tick_last = cyc;
            tick_seen++;
        end
        case (pop_mode)
            1: fifo_pop = fifo_valid;
            2: fifo_pop = fifo_full && phy_rd_en;
            3: fifo_pop = 1'b1;
            default: fifo_pop = 1'b0;
        endcase
        if (fifo_pop && fifo_valid && got_n < 64) begin
            got[got_n] = fifo_word;
            got_n++;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        dn_ready = 1'b0;
        phy_cell_avail = 1'b0;
        pop_mode = 0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic run_cell(input int garbage, input int base, input int mode);
        int waited;
        int bad_hold;
        for (int i = 0; i < garbage; i++) phy_mem[i] = {1'b0, 8'(8'hA0 + i)};
        for (int i = 0; i < 53; i++) phy_mem[garbage + i] = {(i == 0), 8'(base + i)};
        phy_len = garbage + 53; phy_idx = 0; got_n = 0;
        rd_cnt = 0; rd_last = -1; rd_gap_bad = 0;
        pop_mode = mode;
        phy_cell_avail = 1'b1;
        waited = 0;
        while (!cell_pending && waited < 50) begin @(negedge clk); #1; waited++; end
        chk("R3 pending raised", cell_pending, cell_pending, 1);
        bad_hold = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (!cell_pending || phy_rd_en || rd_cnt != 0) bad_hold++;
        end
        chk("R3 pending held without reads", bad_hold == 0, bad_hold, 0);
        in_xfer = 1'b1;
        dn_ready = 1'b1;
        phy_cell_avail = 1'b0;
        waited = 0;
        while (rd_cnt < phy_len && waited < 2000) begin @(negedge clk); #1; waited++; end
        repeat (2) @(negedge clk);
        #1 in_xfer = 1'b0;
        if (mode != 0) pop_mode = 1;
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic check_cell(input string tag, input int base, input int n);
        int mism = 0;
        for (int i = 0; i < n; i++)
            if (got[i] !== {(i == 0), 8'(base + i)}) mism++;
        chk({tag, " entry count"}, got_n == n, got_n, n);
        chk({tag, " tag/data mismatches"}, mism == 0, mism, 0);
    endtask

    initial begin : main
        int bad;
        do_reset();
        // R1
        chk("R1 pending", cell_pending == 0, cell_pending, 0);
        chk("R1 rd_en", phy_rd_en == 0, phy_rd_en, 0);
        chk("R1 valid/full", !fifo_valid && !fifo_full, {fifo_valid, fifo_full}, 0);
        chk("R1 errors", !ovf_err && !frm_err, {ovf_err, frm_err}, 0);

        // R10: pop on empty, idle junk on PHY lines ignored (R11)
        pop_mode = 3;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (fifo_valid) bad++;
        end
        chk("R10 empty pop ignored", bad == 0, bad, 0);
        pop_mode = 0;

        // Normal cell: R4, R5
        run_cell(0, 8'h10, 1);
        chk("R4 reads in cell", rd_cnt == 53, rd_cnt, 53);
        chk("R4 no gap between reads", rd_gap_bad == 0, rd_gap_bad, 0);
        check_cell("R5 normal", 8'h10, 53);
        chk("R10 order kept after empty pops", got[0] === 9'h110, got[0], 9'h110);
        chk("R6 no overflow with prompt consumer", ovf_err == 0, ovf_err, 0);
        chk("R8 no framing error", frm_err == 0, frm_err, 0);

        // R9: grant still high, cell still waiting
        phy_cell_avail = 1'b1;
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (cell_pending) bad++;
        end
        chk("R9 no pending while grant held", bad == 0, bad, 0);
        dn_ready = 1'b0;
        repeat (4) @(negedge clk); #1;
        chk("R9 pending after grant drop", cell_pending == 1, cell_pending, 1);

        // Framing: 3 garbage bytes before start-of-cell (R8)
        run_cell(3, 8'h40, 1);
        dn_ready = 1'b0;
        chk("R8 garbage read then cell", rd_cnt == 56, rd_cnt, 56);
        chk("R8 framing flag set", frm_err == 1, frm_err, 1);
        check_cell("R8 after hunt", 8'h40, 53);

        // Sticky framing flag across a clean cell
        run_cell(0, 8'h80, 1);
        dn_ready = 1'b0;
        chk("R8 framing flag sticky", frm_err == 1, frm_err, 1);
        check_cell("R5 second cell", 8'h80, 53);

        // Simultaneous write and pop on a full FIFO (R7)
        do_reset();
        chk("R1 errors cleared by reset", !ovf_err && !frm_err, {ovf_err, frm_err}, 0);
        run_cell(0, 8'hC0, 2);
        dn_ready = 1'b0;
        chk("R7 no overflow on write+pop at full", ovf_err == 0, ovf_err, 0);
        check_cell("R7 stream", 8'hC0, 53);

        // Overflow with no consumer (R6)
        do_reset();
        run_cell(0, 8'h20, 0);
        chk("R6 fifo full", fifo_full == 1, fifo_full, 1);
        chk("R6 overflow flag", ovf_err == 1, ovf_err, 1);
        pop_mode = 1;
        repeat (6) @(negedge clk); #1;
        chk("R6 only two kept", got_n == 2, got_n, 2);
        chk("R6 first kept", got[0] === 9'h120, got[0], 9'h120);
        chk("R6 second kept", got[1] === 9'h021, got[1], 9'h021);
        chk("R6 overflow sticky", ovf_err == 1, ovf_err, 1);
        dn_ready = 1'b0;

        // R2, R11
        chk("R2 ticks observed", tick_seen > 100, tick_seen, 101);
        chk("R2 tick period", tick_bad == 0, tick_bad, 0);
        chk("R11 no stray reads", rd_stray == 0, rd_stray, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule